// File: doc/BRIEF.md
# Multiplied-Clock Stop Detector

This block watches a clock produced by a frequency multiplier and reports when that clock stops. The monitored clock comes in as a toggle signal that may be asynchronous. A two-stage synchronizer brings it into the domain of an always-running reference clock, and an edge detector then looks for transitions. A counter advances on each reference tick and restarts at every observed edge. When a programmable number of ticks passes with no edge, a sticky fail flag is set. Software clears the flag by writing 1 to it. An interrupt line is driven from the flag, gated by its own enable.

The same control word can also start a relock of the multiplier. The relock command stays high until the multiplier signals that lock is complete and its output is stable. It then drops without any software action. While a relock is running, stop detection is held off so that the expected gap in the multiplied clock is not reported as a failure.

Control is a small state machine with three states. `OFF` means the detector is disabled and no relock is running. `WATCH` means the detector is enabled and counting. `RELOCK` means a relock is in progress and detection is suppressed. The transitions are:

- `OFF` to `WATCH` when the enable bit is written to 1.
- `WATCH` to `OFF` when the enable bit is written to 0.
- `OFF` or `WATCH` to `RELOCK` when a relock is written.
- `RELOCK` to `WATCH` or `OFF` when the lock-done input arrives. The target depends on the enable bit at that moment.

Top module: `mult_clk_fail_det`

## Requirements
- R1: Stop detection runs only while the detector enable bit (`ctl_wdata[0]`, latched on a `ctl_we` write) is 1. With the enable bit at 0, any number of ticks without an edge leaves `fail_flag` at 0.
- R2: A stop is declared on the reference tick that completes W consecutive ticks with no synchronized edge. W is the window register, which resets to 8 and is loaded by `win_we`/`win_wdata`. `fail_flag` is 1 in the cycle after that tick. After W-1 such ticks it is still 0. A window value of 0 behaves as 1.
- R3: `fail_flag` is sticky. It stays 1 after the monitored clock resumes, and falls only on a write with `ctl_wdata[2]` = 1. If a clear and a new stop fall in the same cycle, the flag ends up set.
- R4: `irq` is 1 exactly when `fail_flag` is 1 and the interrupt enable bit (`ctl_wdata[1]`, latched on a write) is 1.
- R5: A write with `ctl_wdata[3]` = 1 raises `relock_cmd` in the next cycle. `relock_cmd` holds until `lock_done` is seen and is 0 in the cycle after that. Writing 0 to bit 3 has no effect.
- R6: While `relock_cmd` is 1, `fail_flag` cannot become set. After relock ends with detection enabled, the window starts afresh from zero ticks.
- R7: Either transition of `mon_toggle` counts as an edge once it has passed the two-stage synchronizer, and an edge restarts the tick count.
- R8: After reset, `fail_flag`, `irq` and `relock_cmd` are 0, the detector and interrupt enables are 0, and the window is 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, always running |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| mon_toggle | input | 1 | Monitored clock as a toggle, asynchronous |
| lock_done | input | 1 | Multiplier reports lock complete and output stable |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control bits: [0] detect enable, [1] irq enable, [2] clear fail (W1C), [3] start relock |
| win_we | input | 1 | Window register write strobe |
| win_wdata | input | WIN_W | New window length in ticks |
| fail_flag | output | 1 | Sticky stop indication |
| irq | output | 1 | Fail interrupt |
| relock_cmd | output | 1 | Relock request to the multiplier |

## Verification
Every window from 0 to 8 is swept, with the bench placing the last edge and driving each tick itself. This catches an off-by-one in the terminal count: such a design would flag one tick early or one tick late. A restart edge placed just before expiry checks that an edge really resets the count; a design that ignored edges would flag a clock that is running. Other checks target the flag's stickiness across a resumed clock and the case where a clear collides with a fresh stop; a design with the wrong priority would lose a real failure. The bench also ticks well past the window during a relock, where a design without suppression would report a false stop. It then checks that a fresh window starts when lock completes; a design that kept the old count would fire early.

// File: rtl/cmfd_pkg.sv
package cmfd_pkg;
    typedef enum logic [1:0] {
        S_OFF    = 2'd0,
        S_WATCH  = 2'd1,
        S_RELOCK = 2'd2
    } cmfd_state_e;

    localparam int CTL_W      = 4;
    localparam int CTL_DET    = 0;
    localparam int CTL_IRQ    = 1;
    localparam int CTL_CLR    = 2;
    localparam int CTL_RELOCK = 3;
endpackage

// File: rtl/cmfd_edge_sync.sv
module cmfd_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic edge_seen
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign edge_seen = sync_q ^ prev_q;
endmodule

// File: rtl/cmfd_window.sv
module cmfd_window #(
    parameter int WIN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             edge_seen,
    input  logic             tick,
    input  logic [WIN_W-1:0] limit,
    output logic             expire
);
    logic [WIN_W-1:0] cnt_q;
    logic [WIN_W-1:0] eff_limit;
    logic [WIN_W-1:0] last_idx;

    assign eff_limit = (limit == '0) ? WIN_W'(1) : limit;
    assign last_idx  = eff_limit - WIN_W'(1);
    assign expire    = run && tick && !edge_seen && (cnt_q == last_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || edge_seen) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + WIN_W'(1);
        end
    end
endmodule

// File: rtl/mult_clk_fail_det.sv
module mult_clk_fail_det
    import cmfd_pkg::*;
#(
    parameter int WIN_W   = 4,
    parameter int WIN_DEF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             mon_toggle,
    input  logic             lock_done,
    input  logic             ctl_we,
    input  logic [3:0]       ctl_wdata,
    input  logic             win_we,
    input  logic [WIN_W-1:0] win_wdata,
    output logic             fail_flag,
    output logic             irq,
    output logic             relock_cmd
);
    cmfd_state_e      state_q, state_d;
    logic             det_en_q, irq_en_q;
    logic [WIN_W-1:0] win_q;
    logic             edge_seen, expire;
    logic             det_en_d, relock_wr, clr_wr;

    assign det_en_d  = ctl_we ? ctl_wdata[CTL_DET] : det_en_q;
    assign relock_wr = ctl_we && ctl_wdata[CTL_RELOCK];
    assign clr_wr    = ctl_we && ctl_wdata[CTL_CLR];

    cmfd_edge_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (mon_toggle),
        .edge_seen (edge_seen)
    );

    cmfd_window #(.WIN_W(WIN_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == S_WATCH),
        .edge_seen (edge_seen),
        .tick      (ref_tick),
        .limit     (win_q),
        .expire    (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_en_q <= 1'b0;
            irq_en_q <= 1'b0;
            win_q    <= WIN_W'(WIN_DEF);
        end else begin
            if (ctl_we) begin
                det_en_q <= ctl_wdata[CTL_DET];
                irq_en_q <= ctl_wdata[CTL_IRQ];
            end
            if (win_we) begin
                win_q <= win_wdata;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (relock_wr)     state_d = S_RELOCK;
                else if (det_en_d) state_d = S_WATCH;
            end
            S_WATCH: begin
                if (relock_wr)      state_d = S_RELOCK;
                else if (!det_en_d) state_d = S_OFF;
            end
            S_RELOCK: begin
                if (!relock_wr && lock_done)
                    state_d = det_en_d ? S_WATCH : S_OFF;
            end
            default: state_d = S_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            relock_cmd <= 1'b0;
            fail_flag  <= 1'b0;
        end else begin
            relock_cmd <= (state_d == S_RELOCK);
            if (expire)      fail_flag <= 1'b1;
            else if (clr_wr) fail_flag <= 1'b0;
        end
    end

    assign irq = fail_flag && irq_en_q;
endmodule

// File: rtl/cmfd_checker.sv
module cmfd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_we,
    input logic [3:0] ctl_wdata,
    input logic       lock_done,
    input logic       fail_flag,
    input logic       irq,
    input logic       relock_cmd,
    input logic       det_en_q
);
    p_irq_needs_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> fail_flag);

    p_fail_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fail_flag && !(ctl_we && ctl_wdata[2]) |=> fail_flag);

    p_relock_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_wdata[3] |=> relock_cmd);

    p_relock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        relock_cmd && !lock_done |=> relock_cmd);

    p_no_fail_in_relock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        relock_cmd && !fail_flag |=> !fail_flag);

    p_rise_needs_enable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en_q && !fail_flag |=> !fail_flag);
endmodule

bind mult_clk_fail_det cmfd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .lock_done  (lock_done),
    .fail_flag  (fail_flag),
    .irq        (irq),
    .relock_cmd (relock_cmd),
    .det_en_q   (det_en_q)
);

// File: tb/tb_mult_clk_fail_det.sv
`timescale 1ns/1ps
module tb_mult_clk_fail_det;
    localparam int WIN_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_tick = 1'b0;
    logic             mon_toggle = 1'b0;
    logic             lock_done = 1'b0;
    logic             ctl_we = 1'b0;
    logic [3:0]       ctl_wdata = '0;
    logic             win_we = 1'b0;
    logic [WIN_W-1:0] win_wdata = '0;
    logic             fail_flag, irq, relock_cmd;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #2.5 clk = ~clk;

    mult_clk_fail_det #(.WIN_W(WIN_W), .WIN_DEF(8)) dut (.*);

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_fail   = n_fail + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [3:0] d);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = d;
        @(negedge clk); ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic win_write(input logic [WIN_W-1:0] d);
        @(negedge clk); win_we = 1'b1; win_wdata = d;
        @(negedge clk); win_we = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); ref_tick = 1'b1;
        @(negedge clk); ref_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic mon_edge();
        @(negedge clk); mon_toggle = ~mon_toggle;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 fail", fail_flag, 1'b0);
        check("R8 irq", irq, 1'b0);
        check("R8 relock", relock_cmd, 1'b0);

        // R1: disabled detector never flags
        ticks(20);
        check("R1 disabled", fail_flag, 1'b0);

        // R8/R2: default window of 8
        ctl_write(4'b0001);
        mon_edge();
        ticks(7);
        check("R2 default w-1", fail_flag, 1'b0);
        tick();
        check("R2 default w", fail_flag, 1'b1);
        check("R4 irq off", irq, 1'b0);
        ctl_write(4'b0011);
        check("R4 irq on", irq, 1'b1);
        ctl_write(4'b0101);
        check("R3 clear", fail_flag, 1'b0);
        check("R4 irq after clear", irq, 1'b0);

        // R2: sweep windows 0..8
        for (int w = 0; w <= 8; w++) begin
            int eff;
            eff = (w == 0) ? 1 : w;
            win_write(WIN_W'(w));
            mon_edge();
            ticks(eff - 1);
            check("R2 sweep early", fail_flag, 1'b0);
            tick();
            check("R2 sweep expire", fail_flag, 1'b1);
            ctl_write(4'b0101);
        end

        // R7: edge restarts count
        win_write(4);
        mon_edge();
        ticks(3);
        mon_edge();
        ticks(3);
        check("R7 restart", fail_flag, 1'b0);
        tick();
        check("R7 expire after restart", fail_flag, 1'b1);

        // R3: sticky across resumed clock
        mon_edge();
        mon_edge();
        check("R3 sticky", fail_flag, 1'b1);
        ctl_write(4'b0101);

        // R3: set wins over clear in same cycle
        mon_edge();
        ticks(3);
        @(negedge clk); ref_tick = 1'b1; ctl_we = 1'b1; ctl_wdata = 4'b0101;
        @(negedge clk); ref_tick = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
        check("R3 set over clear", fail_flag, 1'b1);
        ctl_write(4'b0101);

        // R1: disabling stops detection
        ctl_write(4'b0000);
        ticks(12);
        check("R1 disabled again", fail_flag, 1'b0);
        ctl_write(4'b0001);

        // R5/R6: relock
        win_write(3);
        mon_edge();
        ctl_write(4'b1001);
        check("R5 relock set", relock_cmd, 1'b1);
        ticks(10);
        check("R6 suppressed", fail_flag, 1'b0);
        check("R5 relock held", relock_cmd, 1'b1);
        @(negedge clk); lock_done = 1'b1;
        @(negedge clk); lock_done = 1'b0;
        check("R5 relock cleared", relock_cmd, 1'b0);
        ticks(2);
        check("R6 fresh window early", fail_flag, 1'b0);
        tick();
        check("R6 fresh window expire", fail_flag, 1'b1);
        ctl_write(4'b0101);

        // R5: writing 0 to relock bit has no effect
        ctl_write(4'b0001);
        check("R5 zero write", relock_cmd, 1'b0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule